// File: doc/BRIEF.md
# Timer Capture Unit with Event Prescaler

This block records when something happens on an external input. An asynchronous pin passes through a two-stage synchroniser, and its edges are turned into capture events. On each qualified event the block copies a 16-bit timer value, supplied by a neighbouring counter, into a capture register and sets a capture flag. Software reads the frozen value and acknowledges the flag with a one-cycle clear strobe.

A 4-bit mode field selects the event. Capture can happen on a falling edge or on a rising edge. It can also happen on every fourth or every sixteenth rising edge, counted by a small prescale counter. The prescale counter is cleared only when the mode field is set to zero. Software may change the mode while the block runs, for example to alternate the edge polarity between captures. Such a change can produce an apparent edge and a capture, and the block defines exactly when that happens.

The block does not advance or reset the timer, and it has no interrupt enable.

Top module: `evt_capture`

## Requirements
- R1: After a synchronous reset, `cap_val_o` is 0 and `cap_flag_o` is 0.
- R2: In mode 4'b0100, a falling pin edge causes a capture. The capture happens on the third rising clock edge after the pin changes: two edges for the synchroniser and one for the capture register. Before that edge the outputs are unchanged. A rising edge causes no capture.
- R3: In mode 4'b0101, each rising pin edge causes a capture with the same three-edge latency. A falling edge causes no capture.
- R4: In mode 4'b0110, a capture happens on every fourth rising pin edge, counted from the last clear of the prescaler (the 4th, 8th, and so on).
- R5: In mode 4'b0111, a capture happens on every sixteenth rising pin edge, counted from the last clear of the prescaler.
- R6: Mode values outside 4'b0100 to 4'b0111 never capture. Pin edges leave both `cap_val_o` and `cap_flag_o` unchanged.
- R7: Setting the mode to 4'b0000 clears the prescale count. The next divided capture then needs a full four (or sixteen) new rising edges.
- R8: On a capture, `cap_val_o` takes the full 16-bit `timer_i` value present at that clock edge and `cap_flag_o` is set. A later capture overwrites the value even while the flag is still set, and the flag stays set.
- R9: `flag_clr_i` clears `cap_flag_o` at the next clock edge. If a capture occurs at the same edge, the flag stays set.
- R10: The unit folds edge polarity into the synchronised level. Changing between modes 4'b0100 and 4'b0101 (or entering 4'b0100 from a non-capture mode) therefore causes a capture at the next clock edge whenever the synchronised pin is at the level the new mode treats as asserted: high for rising, low for falling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous event pin |
| timer_i | input | 16 | Current timer value |
| mode_i | input | 4 | Event mode select |
| flag_clr_i | input | 1 | One-cycle strobe that clears the capture flag |
| cap_val_o | output | 16 | Captured timer value |
| cap_flag_o | output | 1 | Capture flag |

## Verification
The checker watches several behaviours on every cycle. Non-capture modes must leave the register still. Each internal capture event must load the timer value and set the flag. The flag must hold, clear or win against a clear exactly as required. A divide-by-four capture must only fire on the fourth count, and mode zero must empty the prescale counter.

Some behaviours only the bench scenarios can show. These are the three-edge pin latency, the edge counting across all sixteen mode values, the restart of counting after a prescaler clear, and the apparent edge caused by a polarity switch. All of them depend on sequences of pin activity rather than on a single cycle.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    localparam int MODE_W   = 4;
    localparam int PRE_W    = 4;   // enough for divide by 16
    localparam int PRE_LO_W = 2;   // enough for divide by 4

    typedef enum logic [1:0] {
        SEL_FALL  = 2'b00,
        SEL_RISE  = 2'b01,
        SEL_DIV4  = 2'b10,
        SEL_DIV16 = 2'b11
    } evt_sel_e;

    typedef struct packed {
        logic     active;   // capture group selected
        logic     wipe;     // prescaler clear request
        evt_sel_e sel;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
        mode_dec_t d;
        d.active = (m[MODE_W-1:2] == 2'b01);
        d.wipe   = (m == '0);
        d.sel    = evt_sel_e'(m[1:0]);
        return d;
    endfunction

    function automatic logic sel_is_div(input evt_sel_e s);
        return (s == SEL_DIV4) || (s == SEL_DIV16);
    endfunction

endpackage

// File: rtl/evt_capture_sync.sv
module evt_capture_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/evt_capture_edge.sv
module evt_capture_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic invert_i,
    output logic pulse_o
);
    logic lvl_eff;
    logic lvl_prev;

    assign lvl_eff = lvl_i ^ invert_i;

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= 1'b0;
        else     lvl_prev <= lvl_eff;
    end

    assign pulse_o = lvl_eff & ~lvl_prev;
endmodule

// File: rtl/evt_capture_prescale.sv
module evt_capture_prescale #(
    parameter int CNT_W = 4,
    parameter int LO_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             count_i,
    input  logic             div_hi_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] FULL_HI = '1;
    localparam logic [LO_W-1:0]  FULL_LO = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear_i)  cnt <= '0;
        else if (count_i)    cnt <= cnt + 1'b1;
    end

    assign hit_o = count_i && (div_hi_i ? (cnt == FULL_HI)
                                        : (cnt[LO_W-1:0] == FULL_LO));
    assign cnt_o = cnt;
endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_capture_pkg::*;
#(
    parameter int TW        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic [TW-1:0]     timer_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              flag_clr_i,
    output logic [TW-1:0]     cap_val_o,
    output logic              cap_flag_o
);
    mode_dec_t        dec;
    logic             pin_s;
    logic             invert;
    logic             edge_pulse;
    logic             pre_count;
    logic             pre_hit;
    logic [PRE_W-1:0] pre_cnt;
    logic             cap_evt;

    assign dec    = decode_mode(mode_i);
    assign invert = dec.active && (dec.sel == SEL_FALL);

    evt_capture_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
    );

    evt_capture_edge u_edge (
        .clk(clk), .rst(rst), .lvl_i(pin_s), .invert_i(invert),
        .pulse_o(edge_pulse)
    );

    assign pre_count = edge_pulse && dec.active && sel_is_div(dec.sel);

    evt_capture_prescale #(.CNT_W(PRE_W), .LO_W(PRE_LO_W)) u_pre (
        .clk(clk), .rst(rst), .clear_i(dec.wipe), .count_i(pre_count),
        .div_hi_i(dec.sel == SEL_DIV16), .hit_o(pre_hit), .cnt_o(pre_cnt)
    );

    assign cap_evt = dec.active && edge_pulse &&
                     (sel_is_div(dec.sel) ? pre_hit : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val_o  <= '0;
            cap_flag_o <= 1'b0;
        end else begin
            if (cap_evt) begin
                cap_val_o  <= timer_i;
                cap_flag_o <= 1'b1;
            end else if (flag_clr_i) begin
                cap_flag_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
    parameter int TW = 16,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    mode_i,
    input logic [TW-1:0] timer_i,
    input logic          flag_clr_i,
    input logic [TW-1:0] cap_val_o,
    input logic          cap_flag_o,
    input logic          cap_evt,
    input logic [PW-1:0] pre_cnt
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cap_val_o == '0 && !cap_flag_o));

    // R6
    idle_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i[3:2] != 2'b01) |=> $stable(cap_val_o));

    // R8
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_flag_o && cap_val_o == $past(timer_i)));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_evt && !flag_clr_i) |=> $stable(cap_flag_o));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !cap_evt) |=> !cap_flag_o);

    // R4
    div4_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && mode_i == 4'b0110) |-> (pre_cnt[1:0] == 2'b11));

    // R7
    pre_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'b0000) |=> (pre_cnt == '0));
endmodule

bind evt_capture evt_capture_chk #(.TW(TW), .PW(evt_capture_pkg::PRE_W)) u_chk (
    .clk(clk), .rst(rst), .mode_i(mode_i), .timer_i(timer_i),
    .flag_clr_i(flag_clr_i), .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o),
    .cap_evt(cap_evt), .pre_cnt(pre_cnt)
);

// File: tb/evt_capture_tb.sv
module evt_capture_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_i = 1'b0;
    logic [15:0] timer_i = '0;
    logic [3:0]  mode_i = '0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        cap_flag_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] tval = 16'h0101;
    logic [15:0] exp_val = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    evt_capture u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .timer_i(timer_i),
        .mode_i(mode_i), .flag_clr_i(flag_clr_i),
        .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        tick();
        flag_clr_i = 1'b0;
        check(cap_flag_o == 1'b0, "R9 clear", {31'b0, cap_flag_o}, 32'd0);
    endtask

    // drive the pin and check the capture at the third edge
    task automatic pin_step(input logic v, input bit exp_cap, input bit do_clr,
                            input string req);
        tval    = tval + 16'h1357;
        timer_i = tval;
        pin_i   = v;
        tick();
        tick();
        check(cap_val_o == exp_val, {req, " early value"},
              {16'b0, cap_val_o}, {16'b0, exp_val});
        tick();
        if (exp_cap) exp_val = tval;
        if (exp_cap)
            check(cap_flag_o == 1'b1, {req, " flag"}, {31'b0, cap_flag_o}, 32'd1);
        check(cap_val_o == exp_val, {req, " value"},
              {16'b0, cap_val_o}, {16'b0, exp_val});
        if (!exp_cap && do_clr)
            check(cap_flag_o == 1'b0, {req, " no flag"}, {31'b0, cap_flag_o}, 32'd0);
        if (exp_cap && do_clr) clear_flag();
    endtask

    function automatic bit rise_cap(input int m, input int idx);
        case (m)
            5:       return 1'b1;
            6:       return (idx % 4) == 3;
            7:       return (idx % 16) == 15;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check(cap_val_o == '0, "R1 value", {16'b0, cap_val_o}, 32'd0);
        check(cap_flag_o == 1'b0, "R1 flag", {31'b0, cap_flag_o}, 32'd0);

        // sweep every mode value with 20 pin pulses
        for (int m = 0; m < 16; m++) begin
            mode_i = 4'd0;
            tick();
            tval    = tval + 16'h0F0F;
            timer_i = tval;
            mode_i  = m[3:0];
            tick();
            if (m == 4) begin
                exp_val = tval;   // R10 entering falling mode with pin low
                check(cap_flag_o == 1'b1, "R10 entry flag", {31'b0, cap_flag_o}, 32'd1);
                check(cap_val_o == exp_val, "R10 entry value",
                      {16'b0, cap_val_o}, {16'b0, exp_val});
                clear_flag();
            end else begin
                check(cap_flag_o == 1'b0, "R6 entry flag", {31'b0, cap_flag_o}, 32'd0);
            end
            for (int i = 0; i < 20; i++) begin
                pin_step(1'b1, rise_cap(m, i), 1'b1,
                         (m == 5) ? "R3" : (m == 6) ? "R4" : (m == 7) ? "R5" :
                         (m == 4) ? "R2" : "R6");
                pin_step(1'b0, (m == 4), 1'b1,
                         (m == 4) ? "R2" : (m >= 5 && m <= 7) ? "R3" : "R6");
            end
        end

        // R7: prescaler cleared by mode zero
        mode_i = 4'd0; tick();
        mode_i = 4'b0110; tick();
        pin_step(1'b1, 1'b0, 1'b1, "R7"); pin_step(1'b0, 1'b0, 1'b1, "R7");
        pin_step(1'b1, 1'b0, 1'b1, "R7"); pin_step(1'b0, 1'b0, 1'b1, "R7");
        mode_i = 4'd0; tick();
        mode_i = 4'b0110; tick();
        for (int i = 0; i < 4; i++) begin
            pin_step(1'b1, (i == 3), 1'b1, "R7");
            pin_step(1'b0, 1'b0, 1'b1, "R7");
        end

        // R8: overwrite while flag set, then R9 clear on a capture edge
        mode_i = 4'b0101; tick();
        pin_step(1'b1, 1'b1, 1'b0, "R8 first");
        pin_step(1'b0, 1'b0, 1'b0, "R8 idle");
        pin_step(1'b1, 1'b1, 1'b0, "R8 overwrite");
        check(cap_flag_o == 1'b1, "R8 flag kept", {31'b0, cap_flag_o}, 32'd1);
        pin_step(1'b0, 1'b0, 1'b0, "R8 idle");
        tval = tval + 16'h2468;
        timer_i = tval;
        pin_i = 1'b1;
        tick();
        tick();
        flag_clr_i = 1'b1;
        tick();
        flag_clr_i = 1'b0;
        exp_val = tval;
        check(cap_flag_o == 1'b1, "R9 capture wins", {31'b0, cap_flag_o}, 32'd1);
        check(cap_val_o == exp_val, "R9 value", {16'b0, cap_val_o}, {16'b0, exp_val});
        clear_flag();

        // R10: polarity switch with pin high
        mode_i = 4'b0100;
        repeat (3) tick();
        check(cap_flag_o == 1'b0, "R10 no flag on falling", {31'b0, cap_flag_o}, 32'd0);
        tval = tval + 16'h0777;
        timer_i = tval;
        mode_i = 4'b0101;
        tick();
        exp_val = tval;
        check(cap_flag_o == 1'b1, "R10 switch flag", {31'b0, cap_flag_o}, 32'd1);
        check(cap_val_o == exp_val, "R10 switch value", {16'b0, cap_val_o}, {16'b0, exp_val});
        clear_flag();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule